// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter with a parallel output bus. A single active-low read/convert line starts each conversion and, when it is high, also enables the output. The converter answers on its busy flag: busy drops shortly after the start and rises again once the new result is sitting in its output register. The controller waits for that rising edge and then turns on the bus with chip-select. It reads the result either as one 16-bit word or as two bytes, using a byte-select line that swaps the two bus halves.

All timing is counted in system clocks. Parameters set the start pulse width, the bus access delay that is waited out after enabling the bus or flipping byte-select, the minimum spacing between conversion starts, and how long the controller waits for busy before it gives up. A result is delivered on a 16-bit output with a one-cycle valid strobe. A conversion that never completes raises a one-cycle timeout strobe instead.

Top module: `adc_par_reader`

## Requirements
- R1: During and right after reset, read/convert and chip-select are high, byte-select is low, and the valid and timeout strobes are low.
- R2: An accepted start drives read/convert and chip-select low together for exactly CONV_PULSE_CYC clock cycles, then returns read/convert high.
- R3: The bus is enabled (chip-select low while read/convert is high) only after busy has been seen low and has then risen again. It is never enabled while busy is low.
- R4: In word mode (mode input 0), byte-select stays low. The result is the full bus sampled after the bus has been enabled for ACCESS_CYC cycles.
- R5: In byte mode (mode input 1), the first read uses byte-select low and takes bus bits 15..8 as result bits 15..8. Byte-select then goes high, and after another ACCESS_CYC cycles bus bits 15..8 are taken as result bits 7..0. This is correct because byte-select high puts bits 7..0 on bus bits 15..8.
- R6: The valid strobe lasts one cycle per completed read. The result output changes only in a cycle where valid is high, and it holds its value between reads.
- R7: A start request while a conversion or read is in progress is ignored, so each accepted start produces exactly one conversion pulse.
- R8: Falling edges of read/convert are at least THRU_CYC cycles apart. A start held high continuously gives falling edges exactly THRU_CYC cycles apart. A single-cycle start request arriving before that spacing has elapsed is dropped, not queued.
- R9: If busy has not risen within BUSY_TIMEOUT_CYC cycles after the start pulse ends, the timeout strobe pulses for one cycle, no result is reported, the bus is not enabled, and the controller accepts new starts again.
- R10: The mode input is captured when a start is accepted. Changing it while the conversion runs does not change how that result is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to start a conversion |
| two_byte_i | input | 1 | Read mode: 0 = one 16-bit word, 1 = two bytes, high byte first |
| busy_i | input | 1 | Converter busy flag, low while converting (asynchronous) |
| bus_i | input | 16 | Converter parallel data bus |
| conv_n_o | output | 1 | Read/convert line, low starts a conversion, high enables output |
| cs_n_o | output | 1 | Active-low chip-select |
| byte_sel_o | output | 1 | Byte-select, high swaps the two bus halves |
| result_o | output | 16 | Last conversion result |
| result_valid_o | output | 1 | One-cycle strobe when result_o updates |
| timeout_o | output | 1 | One-cycle strobe when busy failed to rise in time |

## Verification
A behavioural converter model answers each start with busy low, updates its output register, and then raises busy. It drives a junk pattern onto the bus whenever the bus is disabled or still inside its access window, so a read taken too early or from the wrong half shows up as a wrong word. The corner codes 0000, FFFF, 8000 and 7FFF are read in both modes. In byte mode these codes tell apart a swapped, duplicated or misplaced byte. Random words, random modes, and start pulses or mode flips injected mid-conversion show whether requests are ignored and whether the captured mode holds. A start held high shows the exact spacing between conversions, an early one-cycle start shows that requests are dropped, and a model that never raises busy shows the timeout path.

// File: rtl/adc_rd_pkg.sv
// Shared types for the parallel ADC read controller.
// Assumes: every timing parameter is at least 1 clock cycle.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        RD_IDLE      = 3'd0,
        RD_PULSE     = 3'd1,
        RD_WAIT_LOW  = 3'd2,
        RD_WAIT_HIGH = 3'd3,
        RD_ACC_HI    = 3'd4,
        RD_ACC_LO    = 3'd5
    } rd_state_t;

endpackage

// File: rtl/adc_rd_sync.sv
// Brings the asynchronous busy flag into the clock domain through a flop chain.
// Assumes: the flag idles high, so every stage resets to 1.
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the flag through the chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
// Loadable down counter. After a load of N, done_o is low for N-1 cycles,
// so a state that waits on done_o lasts exactly N cycles.
// Assumes: value_i >= 1 (a value of 0 behaves like 1).
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Load, or count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load_i)          cnt_q <= (value_i == '0) ? '0 : value_i - 1'b1;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // A fresh load of more than one cycle must drop done next cycle.
    p_load_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && value_i > W'(1)) |=> !done_o);
endmodule

// File: rtl/adc_rd_assembler.sv
// Collects the read data into the result word and raises the valid strobe.
// Word mode takes the whole bus. Byte mode stores bus bits 15..8 as the high
// byte, then takes bus bits 15..8 again (now the low byte) to finish the word.
// Assumes: DATA_W is even; the caller issues at most one capture per cycle.
module adc_rd_assembler #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_full_i,
    input  logic              cap_hi_i,
    input  logic              cap_lo_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0]   hi_q;
    logic              hi_ok_q;
    logic [DATA_W-1:0] word_q;
    logic              valid_q;

    // Hold the high byte between the two byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            hi_ok_q <= 1'b0;
        end else if (cap_hi_i) begin
            hi_q    <= bus_i[DATA_W-1:HALF];
            hi_ok_q <= 1'b1;
        end else if (cap_lo_i || cap_full_i) begin
            hi_ok_q <= 1'b0;
        end
    end

    // Publish the finished word together with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= cap_full_i || cap_lo_i;
            if (cap_full_i)    word_q <= bus_i;
            else if (cap_lo_i) word_q <= {hi_q, bus_i[DATA_W-1:HALF]};
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

    // The low byte may only complete a word whose high byte was stored.
    p_hi_before_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lo_i |-> hi_ok_q);
    // The strobe lasts a single cycle.
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // The result moves only together with its strobe.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> valid_q);
endmodule

// File: rtl/adc_par_reader.sv
// Host-side sequencer for a parallel-output SAR converter.
// Pulses read/convert low, waits for busy to fall and rise, then enables the
// bus and reads one word or two bytes. Start spacing, pulse width, access
// delay and the busy timeout are counted in clocks.
// Assumes: busy_i is asynchronous; every timing parameter is at least 1.
module adc_par_reader #(
    parameter int DATA_W           = 16,
    parameter int SYNC_STAGES      = 2,
    parameter int CONV_PULSE_CYC   = 3,
    parameter int ACCESS_CYC       = 5,
    parameter int THRU_CYC         = 500,
    parameter int BUSY_TIMEOUT_CYC = 450
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              two_byte_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              conv_n_o,
    output logic              cs_n_o,
    output logic              byte_sel_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              timeout_o
);
    import adc_rd_pkg::*;

    localparam int PH_MAX = (CONV_PULSE_CYC > ACCESS_CYC) ? CONV_PULSE_CYC : ACCESS_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TH_W   = $clog2(THRU_CYC + 1);
    localparam int TO_W   = $clog2(BUSY_TIMEOUT_CYC + 1);
    localparam int GW     = TH_W + 1;
    localparam int WW     = TO_W + 1;

    rd_state_t         state_q, state_d;
    logic              mode_q;
    logic              busy_s;
    logic              ph_load, th_load, to_load;
    logic [PH_W-1:0]   ph_val;
    logic              ph_done, th_done, to_done;
    logic              cap_full, cap_hi, cap_lo;
    logic              fault_d, fault_q;
    logic              accept;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(busy_i), .sync_o(busy_s)
    );

    adc_rd_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load_i(ph_load), .value_i(ph_val), .done_o(ph_done)
    );

    adc_rd_timer #(.W(TH_W)) u_thru (
        .clk(clk), .rst_n(rst_n), .load_i(th_load),
        .value_i(TH_W'(THRU_CYC)), .done_o(th_done)
    );

    adc_rd_timer #(.W(TO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load_i(to_load),
        .value_i(TO_W'(BUSY_TIMEOUT_CYC)), .done_o(to_done)
    );

    adc_rd_assembler #(.DATA_W(DATA_W)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .cap_full_i(cap_full), .cap_hi_i(cap_hi), .cap_lo_i(cap_lo),
        .bus_i(bus_i), .word_o(result_o), .valid_o(result_valid_o)
    );

    // Next-state, timer loads and capture strobes.
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = PH_W'(ACCESS_CYC);
        th_load  = 1'b0;
        to_load  = 1'b0;
        cap_full = 1'b0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        fault_d  = 1'b0;
        accept   = 1'b0;
        case (state_q)
            RD_IDLE: begin
                if (start_i && th_done) begin
                    state_d = RD_PULSE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(CONV_PULSE_CYC);
                    th_load = 1'b1;
                    accept  = 1'b1;
                end
            end
            RD_PULSE: begin
                if (ph_done) begin
                    state_d = RD_WAIT_LOW;
                    to_load = 1'b1;
                end
            end
            RD_WAIT_LOW: begin
                if (!busy_s) begin
                    state_d = RD_WAIT_HIGH;
                end else if (to_done) begin
                    state_d = RD_IDLE;
                    fault_d = 1'b1;
                end
            end
            RD_WAIT_HIGH: begin
                if (busy_s) begin
                    state_d = RD_ACC_HI;
                    ph_load = 1'b1;
                end else if (to_done) begin
                    state_d = RD_IDLE;
                    fault_d = 1'b1;
                end
            end
            RD_ACC_HI: begin
                if (ph_done) begin
                    if (mode_q) begin
                        cap_hi  = 1'b1;
                        state_d = RD_ACC_LO;
                        ph_load = 1'b1;
                    end else begin
                        cap_full = 1'b1;
                        state_d  = RD_IDLE;
                    end
                end
            end
            RD_ACC_LO: begin
                if (ph_done) begin
                    cap_lo  = 1'b1;
                    state_d = RD_IDLE;
                end
            end
            default: state_d = RD_IDLE;
        endcase
    end

    // State, captured mode and timeout strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            mode_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
            if (accept) mode_q <= two_byte_i;
        end
    end

    assign conv_n_o   = (state_q != RD_PULSE);
    assign cs_n_o     = !(state_q == RD_PULSE || state_q == RD_ACC_HI || state_q == RD_ACC_LO);
    assign byte_sel_o = (state_q == RD_ACC_LO);
    assign timeout_o  = fault_q;

    // ---------------- checking logic ----------------
    logic [15:0]   low_run_q;
    logic [GW-1:0] gap_q;
    logic [WW-1:0] wait_q;

    // Length of the current low run of read/convert.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_run_q <= '0;
        else if (!conv_n_o) low_run_q <= low_run_q + 1'b1;
        else                low_run_q <= '0;
    end

    // Cycles since the last accepted start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        gap_q <= GW'(THRU_CYC);
        else if (accept)                   gap_q <= GW'(1);
        else if (gap_q != GW'(THRU_CYC))   gap_q <= gap_q + 1'b1;
    end

    // Cycles spent waiting for busy, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= '0;
        else if (state_q == RD_WAIT_LOW || state_q == RD_WAIT_HIGH) begin
            if (wait_q != WW'(BUSY_TIMEOUT_CYC)) wait_q <= wait_q + 1'b1;
        end else
            wait_q <= '0;
    end

    // The start pulse has exactly the configured width.
    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n_o) |-> (low_run_q == 16'(CONV_PULSE_CYC)));
    // The bus is never enabled while the synchronised busy is low.
    p_bus_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && conv_n_o) |-> busy_s);
    // Starts respect the minimum spacing.
    p_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (gap_q >= GW'(THRU_CYC)));
    // A timeout fires only after the full wait window.
    p_timeout_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_d |-> (wait_q >= WW'(BUSY_TIMEOUT_CYC - 1)));
    // A timeout never comes with a result.
    p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !result_valid_o);
    // The captured mode holds during a conversion.
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RD_IDLE && !accept) |=> $stable(mode_q));
endmodule

// File: tb/adc_par_reader_tb_top.sv
// Self-checking bench: behavioural converter model, directed corners, seeded random.
module adc_par_reader_tb_top;
    localparam int DW       = 16;
    localparam int PULSE    = 3;
    localparam int ACC      = 5;
    localparam int THRU     = 500;
    localparam int TMO      = 450;
    localparam int BUSY_LOW = 380;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          two_byte = 1'b0;
    logic          busy;
    logic [DW-1:0] bus;
    logic          conv_n, cs_n, byte_sel, valid, timeout;
    logic [DW-1:0] result;

    always #10 clk = ~clk;   // 50 MHz

    adc_par_reader #(
        .DATA_W(DW), .CONV_PULSE_CYC(PULSE), .ACCESS_CYC(ACC),
        .THRU_CYC(THRU), .BUSY_TIMEOUT_CYC(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .two_byte_i(two_byte),
        .busy_i(busy), .bus_i(bus), .conv_n_o(conv_n), .cs_n_o(cs_n),
        .byte_sel_o(byte_sel), .result_o(result), .result_valid_o(valid),
        .timeout_o(timeout)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [DW-1:0] bus_view(input logic [DW-1:0] w, input logic bsel);
        return bsel ? {w[7:0], w[15:8]} : w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [DW-1:0] m_out = '0;
    logic [DW-1:0] m_next = '0;
    bit            m_stuck = 1'b0;
    int            m_phase = 0;
    int            acc_age = 0;
    logic          conv_prev = 1'b1;
    logic          bs_prev = 1'b0;
    logic          m_busy = 1'b1;

    always @(posedge clk) begin
        conv_prev <= conv_n;
        bs_prev   <= byte_sel;
        if (!(!cs_n && conv_n) || byte_sel != bs_prev) acc_age <= 0;
        else if (acc_age < 100) acc_age <= acc_age + 1;
        if (!rst_n) begin
            m_busy  <= 1'b1;
            m_phase <= 0;
        end else if (conv_prev && !conv_n && !cs_n) begin
            m_phase <= 1;
        end else if (m_phase > 0) begin
            m_phase <= m_phase + 1;
            if (m_phase == 2) m_busy <= 1'b0;
            if (!m_stuck && m_phase == BUSY_LOW) m_out <= m_next;
            if (!m_stuck && m_phase == BUSY_LOW + 1) begin
                m_busy  <= 1'b1;
                m_phase <= 0;
            end
        end
    end

    assign busy = m_busy;
    assign bus  = (!cs_n && conv_n && acc_age >= 2) ? bus_view(m_out, byte_sel) : 16'hDEAD;

    // ---------------- monitors ----------------
    int            cyc = 0;
    int            low_run = 0;
    int            last_fall = -1;
    int            last_gap = 0;
    int            n_falls = 0;
    int            n_valid = 0;
    int            n_tmo = 0;
    int            bus_viol = 0;
    int            r6_viol = 0;
    int            tmo_viol = 0;
    bit            saw_bsel = 1'b0;
    bit            exp_mode = 1'b0;
    logic [DW-1:0] exp_word = '0;
    logic          p_conv = 1'b1;
    logic          p_valid = 1'b0;
    logic          p_tmo = 1'b0;
    logic [DW-1:0] p_result = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!conv_n) low_run++;
            else if (low_run > 0) begin
                check(low_run == PULSE, "R2 pulse width", low_run, PULSE);
                low_run = 0;
            end
            if (p_conv && !conv_n) begin
                if (last_fall >= 0) begin
                    last_gap = cyc - last_fall;
                    check(last_gap >= THRU, "R8 start spacing", last_gap, THRU);
                end
                last_fall = cyc;
                n_falls++;
            end
            if (!cs_n && conv_n && !m_busy) bus_viol++;
            if (byte_sel) saw_bsel = 1'b1;
            if (valid) begin
                n_valid++;
                check(result == exp_word, exp_mode ? "R5 byte-mode result" : "R4 word-mode result",
                      result, exp_word);
                if (p_valid) r6_viol++;
            end else if (result != p_result) r6_viol++;
            if (timeout) begin
                n_tmo++;
                if (p_tmo) tmo_viol++;
            end
        end
        p_conv   = conv_n;
        p_valid  = valid;
        p_tmo    = timeout;
        p_result = result;
    end

    // ---------------- stimulus ----------------
    task automatic do_conv(input bit mode, input logic [DW-1:0] val, input bit stuck, input bit noise);
        int v0, t0, f0;
        @(negedge clk);
        m_next = val; m_stuck = stuck; exp_word = val; exp_mode = mode;
        two_byte = mode; saw_bsel = 1'b0;
        v0 = n_valid; t0 = n_tmo; f0 = n_falls;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (noise) begin
            repeat (50) @(negedge clk);
            two_byte = !mode;          // R10: must not alter this read
            start = 1'b1;              // R7: must be ignored
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 2000 && n_valid == v0 && n_tmo == t0; k++) @(negedge clk);
        if (!stuck) begin
            check(n_valid == v0 + 1, "R4 one result per start", n_valid - v0, 1);
            check(saw_bsel == mode, "R10 byte-select follows captured mode", saw_bsel, mode);
        end else begin
            check(n_tmo == t0 + 1, "R9 timeout strobe", n_tmo - t0, 1);
            check(n_valid == v0, "R9 no result on timeout", n_valid - v0, 0);
        end
        check(n_falls == f0 + 1, "R7 one conversion per start", n_falls - f0, 1);
        repeat (THRU) @(negedge clk);
        m_stuck = 1'b0;
    endtask

    initial begin
        int f0;
        logic [DW-1:0] corners [4];
        corners[0] = 16'h0000; corners[1] = 16'hFFFF;
        corners[2] = 16'h8000; corners[3] = 16'h7FFF;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        check(conv_n && cs_n && !byte_sel && !valid && !timeout, "R1 reset state",
              {conv_n, cs_n, byte_sel, valid, timeout}, 5'b11000);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(conv_n && cs_n && !byte_sel && !valid && !timeout, "R1 after reset",
              {conv_n, cs_n, byte_sel, valid, timeout}, 5'b11000);

        do_conv(1'b0, 16'hA55A, 1'b0, 1'b0);   // R4
        do_conv(1'b1, 16'h12F0, 1'b0, 1'b0);   // R5
        for (int i = 0; i < 4; i++) begin
            do_conv(1'b0, corners[i], 1'b0, 1'b0);
            do_conv(1'b1, corners[i], 1'b0, 1'b0);
        end
        do_conv(1'b1, 16'h3C96, 1'b0, 1'b1);   // R7, R10
        do_conv(1'b0, 16'h0F0F, 1'b1, 1'b0);   // R9 stuck busy
        do_conv(1'b1, 16'hBEEF, 1'b0, 1'b0);   // recovery after R9

        // R8: early single-cycle start is dropped
        @(negedge clk);
        m_next = 16'h4411; exp_word = 16'h4411; exp_mode = 1'b0; two_byte = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (420) @(negedge clk);
        f0 = n_falls;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        check(n_falls == f0, "R8 early start dropped", n_falls - f0, 0);
        repeat (THRU) @(negedge clk);

        // R8: start held high gives exact spacing
        start = 1'b1;
        repeat (2 * THRU + 10) @(negedge clk);
        start = 1'b0;
        check(last_gap == THRU, "R8 back-to-back spacing", last_gap, THRU);
        repeat (THRU) @(negedge clk);

        for (int i = 0; i < 20; i++)
            do_conv(1'($urandom % 2), 16'($urandom), 1'b0, ($urandom % 3) == 0);

        check(bus_viol == 0, "R3 bus enabled while busy low", bus_viol, 0);
        check(r6_viol == 0, "R6 strobe width and result hold", r6_viol, 0);
        check(tmo_viol == 0, "R9 timeout strobe width", tmo_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule